// File: doc/BRIEF.md
# Unrolled Single-Block SHA-1 Hash Pipeline with Target Match

This block computes the SHA-1 digest of one pre-padded 512-bit message block in every clock cycle. The 80 compression rounds are laid out as 80 register stages, and each stage carries its own state and its own 16-word slice of the message schedule. A brute-force search front end can therefore present a new candidate block on every cycle. After a fixed latency, the block returns one finished digest per cycle in the same order the blocks went in.

Every block carries a valid bit and a tag through the pipeline, so the search logic can tell which candidate produced each digest. A target digest is loaded through a separate strobe. The output stage compares every valid digest against that target and flags a hit in the same cycle the digest is presented. The chaining value is always the standard initial value, because messages longer than one block are not handled.

Top module: `sha1_search_pipe`

## Requirements
- R1: While `rstN` is low and after its release, `outValid` and `hit` stay 0 until a block that entered with `inValid` high reaches the output.
- R2: `outDigest` is the SHA-1 compression of `inBlock` with the standard initial value, with the five initial-value words added word-wise after round 80. Words are big-endian: `inBlock[511:480]` is schedule word 0, and `outDigest[159:128]` is the first digest word.
- R3: A block sampled at a rising edge appears on `outDigest`/`outValid` after the 81st rising edge, counting the sampling edge as the first.
- R4: A new block is accepted on every cycle. Back-to-back inputs give back-to-back outputs in the same order.
- R5: `outValid` follows the `inValid` pattern delayed by the pipeline latency, and gaps are kept.
- R6: `outTag` equals the `inTag` that entered together with the block now on `outDigest`.
- R7: `hit` is 1 exactly in the cycles in which `outValid` is 1 and `outDigest` equals the stored target.
- R8: When `targetLoad` is 1 at a rising edge, `targetIn` becomes the target from the next cycle on. This also applies to digests that were already in flight when the target was loaded.
- R9: `hit` is 0 whenever `outValid` is 0, even if the held `outDigest` equals the target.
- R10: Asserting `rstN` low discards every block in flight, so none of them ever raises `outValid`. It also clears the target to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A candidate block is present this cycle |
| inTag | input | TAG_W | Identifier travelling with the block |
| inBlock | input | 512 | Padded single message block, word 0 in the top bits |
| targetLoad | input | 1 | Load `targetIn` as the new target |
| targetIn | input | 160 | Target digest value |
| outValid | output | 1 | `outDigest` and `outTag` hold a result |
| outTag | output | TAG_W | Tag of the block whose digest is shown |
| outDigest | output | 160 | Finished digest |
| hit | output | 1 | Valid digest equals the target |

## Verification
The hardest situation to reach is a stale digest that equals the target while `outValid` is low. The digest register keeps its value during bubbles, so a comparator that is not qualified by the valid bit would flag a hit there. The stimulus sends the known block whose digest was loaded as the target, then lets the pipeline drain, and watches `hit` through the idle cycles that follow. A second awkward case loads a new target while the matching block is still halfway through the 80 stages. A third asserts reset while twenty blocks are in flight and confirms that none of them comes out.

// File: rtl/sha1_pipe_pkg.sv
package sha1_pipe_pkg;

  localparam int ROUNDS = 80;
  localparam int WORD_W = 32;
  localparam int WIN_WORDS = 16;
  localparam int BLOCK_W = WORD_W * WIN_WORDS;
  localparam int DIGEST_W = WORD_W * 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } roundState_t;

  // index 0 holds the schedule word consumed by the current round
  typedef logic [WIN_WORDS-1:0][WORD_W-1:0] window_t;

  // strobes from control to datapath: per-stage load enables and output load
  typedef struct packed {
    logic [ROUNDS-1:0] stageEn;
    logic              outEn;
  } strobe_t;

  localparam roundState_t IV_STATE = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                      32'h10325476, 32'hC3D2E1F0};

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t roundFn(input int unsigned t, input word_t b,
                                    input word_t c, input word_t d);
    if (t < 20)      return (b & c) | (~b & d);
    else if (t < 40) return b ^ c ^ d;
    else if (t < 60) return (b & c) | (b & d) | (c & d);
    else             return b ^ c ^ d;
  endfunction

  function automatic word_t roundConst(input int unsigned t);
    if (t < 20)      return 32'h5A827999;
    else if (t < 40) return 32'h6ED9EBA1;
    else if (t < 60) return 32'h8F1BBCDC;
    else             return 32'hCA62C1D6;
  endfunction

endpackage

// File: rtl/sha1_pipe_datapath.sv
module sha1_pipe_datapath
  import sha1_pipe_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [BLOCK_W-1:0]  blockIn,
  output logic [DIGEST_W-1:0] digest
);

  window_t blockWin;
  always_comb begin
    for (int k = 0; k < WIN_WORDS; k++) begin
      blockWin[k] = blockIn[BLOCK_W-1-WORD_W*k -: WORD_W];
    end
  end

  for (genvar s = 0; s < ROUNDS; s++) begin : gStage
    roundState_t curSt, nxtSt, stQ;
    window_t     curWin, nxtWin, winQ;
    word_t       newA, newW;

    if (s == 0) begin : gFirst
      assign curSt  = IV_STATE;
      assign curWin = blockWin;
    end else begin : gLater
      assign curSt  = gStage[s-1].stQ;
      assign curWin = gStage[s-1].winQ;
    end

    always_comb begin
      newA  = rotl(curSt.a, 5) + roundFn(s, curSt.b, curSt.c, curSt.d)
            + curSt.e + roundConst(s) + curWin[0];
      nxtSt = {newA, curSt.a, rotl(curSt.b, 30), curSt.c, curSt.d};
      newW  = rotl(curWin[13] ^ curWin[8] ^ curWin[2] ^ curWin[0], 1);
      nxtWin = {newW, curWin[WIN_WORDS-1:1]};
    end

    always_ff @(posedge clk) begin
      if (strobe.stageEn[s]) begin
        stQ  <= nxtSt;
        winQ <= nxtWin;
      end
    end
  end

  roundState_t lastSt;
  logic [DIGEST_W-1:0] digestQ;
  assign lastSt = gStage[ROUNDS-1].stQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digestQ <= '0;
    end else if (strobe.outEn) begin
      digestQ <= {lastSt.a + IV_STATE.a, lastSt.b + IV_STATE.b, lastSt.c + IV_STATE.c,
                  lastSt.d + IV_STATE.d, lastSt.e + IV_STATE.e};
    end
  end

  assign digest = digestQ;

  AST_ROUND0_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stageEn[0] |=> (gStage[0].stQ.b == IV_STATE.a) &&
                          (gStage[0].stQ.c == rotl(IV_STATE.b, 30))); // R2
  AST_WINDOW_SLIDE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stageEn[1] |=> gStage[1].winQ[WIN_WORDS-2] == $past(gStage[0].winQ[WIN_WORDS-1])); // R2
  AST_DIGEST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outEn |=> $stable(digestQ)); // R9

endmodule

// File: rtl/sha1_pipe_ctrl.sv
module sha1_pipe_ctrl
  import sha1_pipe_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [TAG_W-1:0]    inTag,
  input  logic                targetLoad,
  input  logic [DIGEST_W-1:0] targetIn,
  input  logic [DIGEST_W-1:0] digest,
  output strobe_t             strobe,
  output logic                outValid,
  output logic [TAG_W-1:0]    outTag,
  output logic                hit
);

  localparam int SLOTS = ROUNDS + 1;

  logic [SLOTS-1:0]    validQ;
  logic [TAG_W-1:0]    tagQ [SLOTS];
  logic [DIGEST_W-1:0] targetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= '0;
    else       validQ <= {validQ[SLOTS-2:0], inValid};
  end

  always_ff @(posedge clk) begin
    if (inValid) tagQ[0] <= inTag;
    for (int s = 1; s < SLOTS; s++) begin
      if (validQ[s-1]) tagQ[s] <= tagQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           targetQ <= '0;
    else if (targetLoad) targetQ <= targetIn;
  end

  assign strobe.stageEn = {validQ[ROUNDS-2:0], inValid};
  assign strobe.outEn   = validQ[ROUNDS-1];

  assign outValid = validQ[SLOTS-1];
  assign outTag   = tagQ[SLOTS-1];
  assign hit      = outValid && (digest == targetQ);

  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> outValid); // R9
  AST_TARGET_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(targetLoad) && outValid && digest == $past(targetIn)) |-> hit); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid && !hit); // R10

endmodule

// File: rtl/sha1_search_pipe.sv
module sha1_search_pipe
  import sha1_pipe_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [TAG_W-1:0]    inTag,
  input  logic [BLOCK_W-1:0]  inBlock,
  input  logic                targetLoad,
  input  logic [DIGEST_W-1:0] targetIn,
  output logic                outValid,
  output logic [TAG_W-1:0]    outTag,
  output logic [DIGEST_W-1:0] outDigest,
  output logic                hit
);

  strobe_t strobe;

  sha1_pipe_ctrl #(.TAG_W(TAG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag),
    .targetLoad(targetLoad), .targetIn(targetIn), .digest(outDigest),
    .strobe(strobe), .outValid(outValid), .outTag(outTag), .hit(hit)
  );

  sha1_pipe_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blockIn(inBlock), .digest(outDigest)
  );

endmodule

// File: tb/sim_sha1_search_pipe.sv
`timescale 1ns/1ps
module sim_sha1_search_pipe;

  localparam int TW = 8;
  localparam int DEPTH = 81;
  localparam int HIST = 2048;

  localparam logic [511:0] VEC_BLK [2] = '{
    {32'h61626380, {14{32'h0}}, 32'h00000018},
    {32'h80000000, {15{32'h0}}}
  };
  localparam logic [159:0] VEC_DIG [2] = '{
    160'ha9993e364706816aba3e25717850c26c9cd0d89d,
    160'hda39a3ee5e6b4b0d3255bfef95601890afd80709
  };

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0;
  logic [TW-1:0] inTag = '0;
  logic [511:0] inBlock = '0;
  logic targetLoad = 0;
  logic [159:0] targetIn = '0;
  logic outValid, hit;
  logic [TW-1:0] outTag;
  logic [159:0] outDigest;

  always #10 clk = ~clk;

  sha1_search_pipe #(.TAG_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag), .inBlock(inBlock),
    .targetLoad(targetLoad), .targetIn(targetIn), .outValid(outValid),
    .outTag(outTag), .outDigest(outDigest), .hit(hit)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit monOn = 0;
  bit done = 0;
  int hitCount = 0;
  int validCount = 0;
  logic [159:0] expT = '0;

  logic sentV [HIST];
  logic [159:0] sentD [HIST];
  logic [TW-1:0] sentT [HIST];
  logic ldRec [HIST];
  logic [159:0] ldVal [HIST];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] refHash(input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, tmp;
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      tmp = rl(a, 5) + f + e + k + w[t];
      e = d; d = c; c = rl(b, 30); b = a; a = tmp;
    end
    return {a + 32'h67452301, b + 32'hEFCDAB89, c + 32'h98BADCFE,
            d + 32'h10325476, e + 32'hC3D2E1F0};
  endfunction

  function automatic logic [511:0] genBlock(input int n);
    logic [511:0] blk;
    for (int k = 0; k < 16; k++)
      blk[511-32*k -: 32] = (32'(n) * 32'h9E3779B9) ^ (32'(k) * 32'h7F4A7C15) ^ 32'hC0FFEE11;
    return blk;
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearHist();
    for (int i = 0; i < HIST; i++) begin
      sentV[i] = 0; sentD[i] = '0; sentT[i] = '0; ldRec[i] = 0; ldVal[i] = '0;
    end
    expT = '0;
  endtask

  task automatic drive(input logic v, input logic [511:0] blk, input logic [TW-1:0] tg,
                       input logic ld, input logic [159:0] tgt);
    int idx;
    @(negedge clk);
    inValid = v; inBlock = blk; inTag = tg; targetLoad = ld; targetIn = tgt;
    idx = cyc + 1;
    if (idx < HIST) begin
      sentV[idx] = v; sentD[idx] = v ? refHash(blk) : '0; sentT[idx] = tg;
      ldRec[idx] = ld; ldVal[idx] = tgt;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, 0, '0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; monOn = 0;
    inValid = 0; targetLoad = 0;
    clearHist();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid == 0, "R1 outValid in reset", 160'(outValid), 160'd0);
      check(hit == 0, "R10 hit in reset", 160'(hit), 160'd0);
    end
    @(negedge clk);
    rstN = 1; monOn = 1;
  endtask

  // cycle monitor: expected outputs from the recorded stimulus, latency DEPTH edges
  always @(negedge clk) begin
    if (monOn && !done) begin
      int c, idx;
      logic ev, eh;
      c = cyc;
      if (c < HIST && ldRec[c]) expT = ldVal[c];
      idx = c - (DEPTH - 1);
      ev = (idx >= 0 && idx < HIST) ? sentV[idx] : 1'b0;
      check(outValid == ev, "R4/R5 outValid pattern", 160'(outValid), 160'(ev));
      if (ev) begin
        check(outDigest == sentD[idx], "R2 digest", outDigest, sentD[idx]);
        check(outTag == sentT[idx], "R6 tag", 160'(outTag), 160'(sentT[idx]));
        eh = (sentD[idx] == expT);
        check(hit == eh, "R7 hit on valid digest", 160'(hit), 160'(eh));
      end else begin
        check(hit == 0, "R9 hit without valid", 160'(hit), 160'd0);
      end
      if (hit) hitCount++;
      if (outValid) validCount++;
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 160'd1, 160'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    clearHist();
    doReset();
    idle(DEPTH + 4);  // R1: nothing emerges after release

    // table of known vectors, one at a time
    for (int v = 0; v < 2; v++) begin
      drive(1, VEC_BLK[v], TW'(v + 1), 0, '0);
      n = 0;
      while (!outValid && n < 200) begin
        idle(1);
        n++;
      end
      check(n == DEPTH, "R3 latency", 160'(n), 160'(DEPTH));
      check(outDigest == VEC_DIG[v], "R2 known vector", outDigest, VEC_DIG[v]);
      idle(2);
    end

    // back-to-back stream
    validCount = 0;
    for (int i = 0; i < 40; i++) drive(1, genBlock(i), TW'(i), 0, '0);
    idle(DEPTH + 5);
    check(validCount == 40, "R4 stream count", 160'(validCount), 160'd40);

    // bubbles
    validCount = 0;
    for (int i = 0; i < 30; i++) drive((i % 3) != 1, genBlock(100 + i), TW'(100 + i), 0, '0);
    idle(DEPTH + 5);
    check(validCount == 20, "R5 bubble count", 160'(validCount), 160'd20);

    // hits against a loaded target, then a stale equal digest
    drive(0, '0, '0, 1, VEC_DIG[0]);
    hitCount = 0;
    drive(1, VEC_BLK[0], 8'h5A, 0, '0);
    drive(1, genBlock(7), 8'h11, 0, '0);
    drive(1, VEC_BLK[0], 8'h33, 0, '0);
    idle(DEPTH + 5);
    check(hitCount == 2, "R7 hit count", 160'(hitCount), 160'd2);
    check(outDigest == VEC_DIG[0] && hit == 0, "R9 stale equal digest",
          160'(hit), 160'd0);

    // target loaded while the matching block is in flight
    hitCount = 0;
    drive(1, genBlock(555), 8'h77, 0, '0);
    idle(40);
    drive(0, '0, '0, 1, refHash(genBlock(555)));
    idle(DEPTH);
    check(hitCount == 1, "R8 late target load", 160'(hitCount), 160'd1);

    // reset with blocks in flight
    for (int i = 0; i < 20; i++) drive(1, genBlock(900 + i), TW'(i), 0, '0);
    idle(10);
    doReset();
    validCount = 0;
    hitCount = 0;
    idle(DEPTH + 20);
    check(validCount == 0, "R10 flushed blocks", 160'(validCount), 160'd0);
    check(hitCount == 0, "R10 no hit after flush", 160'(hitCount), 160'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule